// File: doc/BRIEF.md
# GPIO Event Latch and Router

This block watches a bank of general-purpose input pins and turns qualified activity on them into sticky event flags. Each pin first goes through a programmable polarity flip, so either a high or a low level can count as active. It then crosses into the sampling logic through a multi-flop synchronizer. A per-pin run counter advances only on a sampling strobe. The strobe comes from one of two sources, chosen by a sleep-state select input: a fast strobe while the system runs, and a slow real-time strobe while it sleeps. Once a pin has been active on enough consecutive strobes, its event flag sets. The flag then holds until software clears it.

Each flag can be steered to a system-management interrupt line, to a configuration interrupt line, or to neither. It is gated by a per-pin interrupt enable. A separate per-pin wake enable lets a flag raise a wake request. Pins marked as belonging to the main power domain cannot raise a wake request while the sleep select is high. A small word-addressed register port gives read and write access to all configuration and to the flags.

Top module: `gpev_router`

## Requirements
- R1: While `rst_n` is low, every register reads 0 and `smi_o`, `sci_o` and `wake_o` are 0.
- R2: A pin counts as active when its input level XOR its polarity bit (register word 0, bit i for pin i) is 1.
- R3: A flag sets only after its pin has been active on at least 2 consecutive sampling strobes. A pin seen active on a single strobe leaves its flag clear.
- R4: With `sleep_sel` = 0 the sampling strobe is `fast_stb`; with `sleep_sel` = 1 it is `slow_stb`. The unselected strobe has no effect.
- R5: A set flag stays set after its pin goes inactive.
- R6: Writing the flag word (word 5) clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R7: If a pin is still active when its flag is cleared, the flag sets again on the next qualifying strobe. No new edge is needed.
- R8: When a clear and a qualified set hit the same flag in the same cycle, the flag ends up set.
- R9: The steering field of pin i is bits [2i+1:2i] of word 1. 01 selects the management line, 10 selects the configuration line, and 00 or 11 selects neither. A flag never drives both lines.
- R10: `smi_o` is the OR of all flags that are enabled (word 2, bit i) and steered to the management line. `sci_o` is formed the same way for the configuration line. Both are levels that stay high while any contributing flag is set.
- R11: `wake_o` is the OR of the flags whose wake enable (word 3) is set. While `sleep_sel` = 1, flags whose main-domain bit (word 4) is set are excluded.
- R12: Register words 0 to 5 read back polarity, steering, interrupt enable, wake enable, main-domain mask and flags. Words 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpi | input | 16 | Monitored input pins |
| sleep_sel | input | 1 | 1 = sleep state, selects slow strobe and masks main-domain wake |
| fast_stb | input | 1 | Sampling strobe for the running state |
| slow_stb | input | 1 | Sampling strobe for the sleep state |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| smi_o | output | 1 | Management interrupt level |
| sci_o | output | 1 | Configuration interrupt level |
| wake_o | output | 1 | Wake request level |

## Verification
The bench drives pulses that span exactly one strobe and pulses that span exactly two. A design that counts clocks instead of strobes, or sets on the first active sample, flags the short pulse. Clears are issued while the pin is still held active, once at a slow strobe rate and once with a strobe on every cycle. A design that needs a fresh edge stays clear in the first case, and one that lets the clear win loses the flag in the second. Steering codes 00 and 11 and a disabled enable bit are exercised in turn, as is a main-domain flag in both sleep states. A wrong decode, or a wake mask that ignores the sleep select, shows up on the interrupt and wake pins.

// File: rtl/gpev_pkg.sv
package gpev_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [1:0] {
      RT_NONE = 2'b00,
      RT_SMI  = 2'b01,
      RT_SCI  = 2'b10,
      RT_OFF  = 2'b11
   } route_e;

   localparam logic [ADDR_W-1:0] A_POL    = 3'd0;
   localparam logic [ADDR_W-1:0] A_ROUTE  = 3'd1;
   localparam logic [ADDR_W-1:0] A_INTEN  = 3'd2;
   localparam logic [ADDR_W-1:0] A_WAKEEN = 3'd3;
   localparam logic [ADDR_W-1:0] A_CORE   = 3'd4;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;

endpackage

// File: rtl/gpev_sync.sv
module gpev_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpev_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= '0;
         else        stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpev_qual.sv
module gpev_qual #(
   parameter int NUM_IN      = 16,
   parameter int MIN_SAMPLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [NUM_IN-1:0] lvl,
   output logic [NUM_IN-1:0] hit
);

   localparam int CW = (MIN_SAMPLES > 1) ? $clog2(MIN_SAMPLES) : 1;
   localparam logic [CW-1:0] TOP = CW'(MIN_SAMPLES - 1);

   if (MIN_SAMPLES < 1) begin : g_bad_min
      $error("gpev_qual needs MIN_SAMPLES of at least one");
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
      logic [CW-1:0] run_q;
      logic          full;

      assign full   = (run_q == TOP);
      assign hit[i] = stb & lvl[i] & full;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          run_q <= '0;
         else if (stb) begin
            if (!lvl[i])      run_q <= '0;
            else if (!full)   run_q <= run_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/gpev_regs.sv
module gpev_regs
   import gpev_pkg::*;
#(
   parameter int NUM_IN = 16,
   parameter int DW     = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DW-1:0]       wdata,
   input  logic [NUM_IN-1:0]   set_mask,
   output logic [DW-1:0]       rdata,
   output logic [NUM_IN-1:0]   pol_q,
   output logic [2*NUM_IN-1:0] route_q,
   output logic [NUM_IN-1:0]   int_en_q,
   output logic [NUM_IN-1:0]   wake_en_q,
   output logic [NUM_IN-1:0]   core_q,
   output logic [NUM_IN-1:0]   status_q,
   output logic [NUM_IN-1:0]   clr_mask
);

   localparam int RW = 2 * NUM_IN;

   if (RW > DW) begin : g_bad_width
      $error("gpev_regs data width too narrow for steering word");
   end

   assign clr_mask = (we && addr == A_FLAGS) ? wdata[NUM_IN-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q     <= '0;
         route_q   <= '0;
         int_en_q  <= '0;
         wake_en_q <= '0;
         core_q    <= '0;
      end else if (we) begin
         case (addr)
            A_POL:    pol_q     <= wdata[NUM_IN-1:0];
            A_ROUTE:  route_q   <= wdata[RW-1:0];
            A_INTEN:  int_en_q  <= wdata[NUM_IN-1:0];
            A_WAKEEN: wake_en_q <= wdata[NUM_IN-1:0];
            A_CORE:   core_q    <= wdata[NUM_IN-1:0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr_mask) | set_mask;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_POL:    rdata[NUM_IN-1:0] = pol_q;
         A_ROUTE:  rdata[RW-1:0]     = route_q;
         A_INTEN:  rdata[NUM_IN-1:0] = int_en_q;
         A_WAKEEN: rdata[NUM_IN-1:0] = wake_en_q;
         A_CORE:   rdata[NUM_IN-1:0] = core_q;
         A_FLAGS:  rdata[NUM_IN-1:0] = status_q;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpev_router.sv
module gpev_router
   import gpev_pkg::*;
#(
   parameter int NUM_IN      = 16,
   parameter int DW          = 32,
   parameter int MIN_SAMPLES = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] gpi,
   input  logic              sleep_sel,
   input  logic              fast_stb,
   input  logic              slow_stb,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              smi_o,
   output logic              sci_o,
   output logic              wake_o
);

   if (NUM_IN < 1) begin : g_bad_num
      $error("gpev_router needs at least one input");
   end

   logic [NUM_IN-1:0]   pol_q, int_en_q, wake_en_q, core_q, status_q;
   logic [NUM_IN-1:0]   set_mask, clr_mask;
   logic [2*NUM_IN-1:0] route_q;
   logic [NUM_IN-1:0]   raw_lvl, sync_lvl;
   logic [NUM_IN-1:0]   smi_vec, sci_vec, wake_vec;
   logic                smp_stb;

   assign raw_lvl = gpi ^ pol_q;
   assign smp_stb = sleep_sel ? slow_stb : fast_stb;

   gpev_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lvl),
      .q     (sync_lvl)
   );

   gpev_qual #(.NUM_IN(NUM_IN), .MIN_SAMPLES(MIN_SAMPLES)) i_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (smp_stb),
      .lvl   (sync_lvl),
      .hit   (set_mask)
   );

   gpev_regs #(.NUM_IN(NUM_IN), .DW(DW)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .set_mask  (set_mask),
      .rdata     (reg_rdata),
      .pol_q     (pol_q),
      .route_q   (route_q),
      .int_en_q  (int_en_q),
      .wake_en_q (wake_en_q),
      .core_q    (core_q),
      .status_q  (status_q),
      .clr_mask  (clr_mask)
   );

   for (genvar i = 0; i < NUM_IN; i++) begin : g_route
      route_e sel;
      logic   live;
      assign sel        = route_e'(route_q[2*i +: 2]);
      assign live       = status_q[i] & int_en_q[i];
      assign smi_vec[i] = live & (sel == RT_SMI);
      assign sci_vec[i] = live & (sel == RT_SCI);
   end

   assign wake_vec = status_q & wake_en_q & ~(core_q & {NUM_IN{sleep_sel}});

   assign smi_o  = |smi_vec;
   assign sci_o  = |sci_vec;
   assign wake_o = |wake_vec;

endmodule

// File: rtl/gpev_router_chk.sv
module gpev_router_chk #(
   parameter int NUM_IN = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_sel,
   input logic              smp_stb,
   input logic              smi_o,
   input logic              sci_o,
   input logic              wake_o,
   input logic [NUM_IN-1:0] status_q,
   input logic [NUM_IN-1:0] int_en_q,
   input logic [NUM_IN-1:0] wake_en_q,
   input logic [NUM_IN-1:0] core_q,
   input logic [NUM_IN-1:0] set_mask,
   input logic [NUM_IN-1:0] clr_mask
);

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (status_q == '0 && !smi_o && !sci_o && !wake_o));

   a_r3_set_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(status_q)) != '0) |-> $past(smp_stb));

   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(set_mask)) == $past(set_mask)));

   a_r9_one_line: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(status_q & int_en_q) == 1) |-> !(smi_o && sci_o));

   a_r10_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
      (smi_o || sci_o) |-> ((status_q & int_en_q) != '0));

   a_r11_core_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_sel && wake_o) |-> ((status_q & wake_en_q & ~core_q) != '0));

endmodule

bind gpev_router gpev_router_chk #(.NUM_IN(NUM_IN)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep_sel (sleep_sel),
   .smp_stb   (smp_stb),
   .smi_o     (smi_o),
   .sci_o     (sci_o),
   .wake_o    (wake_o),
   .status_q  (status_q),
   .int_en_q  (int_en_q),
   .wake_en_q (wake_en_q),
   .core_q    (core_q),
   .set_mask  (set_mask),
   .clr_mask  (clr_mask)
);

// File: tb/test_gpev_router.sv
`timescale 1ns/1ps
module test_gpev_router;

   localparam int MINW = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [15:0] gpi = '0;
   logic        sleep_sel = 1'b0;
   logic        fast_stb = 1'b0;
   logic        slow_stb = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        smi_o, sci_o, wake_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int fast_div = 2;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpev_router i_gpev_router (
      .clk(clk), .rst_n(rst_n), .gpi(gpi), .sleep_sel(sleep_sel),
      .fast_stb(fast_stb), .slow_stb(slow_stb), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .smi_o(smi_o), .sci_o(sci_o), .wake_o(wake_o)
   );

   // strobe generator
   always @(negedge clk) begin
      cyc++;
      fast_stb = (cyc % fast_div) == 0;
      slow_stb = (cyc % 16) == 0;
   end

   // behavioural reference model
   logic [15:0] m_pol, m_en, m_wk, m_core, m_st;
   logic [31:0] m_rt;
   logic [15:0] m_q[$];
   int          m_run[16];

   always @(posedge clk or negedge rst_n) begin
      logic [15:0] lv, setm, clrm;
      logic        stb;
      if (!rst_n) begin
         m_pol = '0; m_en = '0; m_wk = '0; m_core = '0; m_st = '0; m_rt = '0;
         m_q = {16'h0, 16'h0};
         for (int i = 0; i < 16; i++) m_run[i] = 0;
      end else begin
         stb = sleep_sel ? slow_stb : fast_stb;
         lv = m_q.pop_front();
         m_q.push_back(gpi ^ m_pol);
         setm = '0;
         for (int i = 0; i < 16; i++) begin
            if (stb) begin
               if (lv[i]) begin
                  if (m_run[i] >= MINW - 1) setm[i] = 1'b1;
                  if (m_run[i] < MINW) m_run[i]++;
               end else m_run[i] = 0;
            end
         end
         clrm = (reg_we && reg_addr == 3'd5) ? reg_wdata[15:0] : 16'h0;
         m_st = (m_st & ~clrm) | setm;
         if (reg_we) begin
            case (reg_addr)
               3'd0: m_pol  = reg_wdata[15:0];
               3'd1: m_rt   = reg_wdata;
               3'd2: m_en   = reg_wdata[15:0];
               3'd3: m_wk   = reg_wdata[15:0];
               3'd4: m_core = reg_wdata[15:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic exp_line(input logic [1:0] code);
      logic r = 1'b0;
      for (int i = 0; i < 16; i++)
         if (m_st[i] && m_en[i] && m_rt[2*i +: 2] == code) r = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return {16'h0, m_pol};
         3'd1: return m_rt;
         3'd2: return {16'h0, m_en};
         3'd3: return {16'h0, m_wk};
         3'd4: return {16'h0, m_core};
         3'd5: return {16'h0, m_st};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: got %h expected %h", tag, cyc, got, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      #2;
      if (cmp_on && rst_n) begin
         check("R10 smi_o", {31'h0, smi_o}, {31'h0, exp_line(2'b01)});
         check("R10 sci_o", {31'h0, sci_o}, {31'h0, exp_line(2'b10)});
         check("R11 wake_o", {31'h0, wake_o},
               {31'h0, |(m_st & m_wk & ~(m_core & {16{sleep_sel}}))});
         check("R12 reg_rdata", reg_rdata, exp_rd(reg_addr));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #2;
      check(tag, reg_rdata, exp);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired at cycle %0d: got hang expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      #1 rst_n = 1'b0;
      tick(4);
      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         reg_addr = 3'(a);
         #1 check("R1 reset rdata", reg_rdata, 32'h0);
      end
      check("R1 reset outputs", {29'h0, smi_o, sci_o, wake_o}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      wr(3'd1, 32'h0000_0039);   // pin0 SMI, pin1 SCI, pin2 code 11, pin3 code 00
      wr(3'd2, 32'h0000_FFFF);

      // R2, R10, R5
      gpi[0] = 1'b1; tick(12);
      rd_chk(3'd5, 32'h0001, "R2 active-high pin sets flag");
      check("R10 smi high", {31'h0, smi_o}, 32'h1);
      gpi[0] = 1'b0; tick(12);
      rd_chk(3'd5, 32'h0001, "R5 flag sticky");

      // R3
      gpi[4] = 1'b1; tick(1); gpi[4] = 1'b0; tick(10);
      rd_chk(3'd5, 32'h0001, "R3 single-strobe pulse ignored");
      gpi[5] = 1'b1; tick(4); gpi[5] = 1'b0; tick(10);
      rd_chk(3'd5, 32'h0021, "R3 two-strobe pulse latched");

      // R6
      wr(3'd5, 32'h0);
      rd_chk(3'd5, 32'h0021, "R6 zero write keeps flags");
      wr(3'd5, 32'h1);
      rd_chk(3'd5, 32'h0020, "R6 one clears flag");
      check("R10 smi drops", {31'h0, smi_o}, 32'h0);

      // R7
      gpi[1] = 1'b1; tick(12);
      rd_chk(3'd5, 32'h0022, "R10 sci source set");
      check("R10 sci high", {31'h0, sci_o}, 32'h1);
      wr(3'd5, 32'h2); tick(10);
      rd_chk(3'd5, 32'h0022, "R7 level retrigger");

      // R8
      fast_div = 1; tick(4);
      wr(3'd5, 32'h2);
      rd_chk(3'd5, 32'h0022, "R8 set beats clear");
      fast_div = 2;
      gpi[1] = 1'b0; tick(10);
      wr(3'd5, 32'hFFFF);
      rd_chk(3'd5, 32'h0, "R6 clear all");

      // R9
      gpi[2] = 1'b1; gpi[3] = 1'b1; tick(12);
      rd_chk(3'd5, 32'h000C, "R9 unrouted flags set");
      check("R9 no line for 00/11", {30'h0, smi_o, sci_o}, 32'h0);
      gpi[2] = 1'b0; gpi[3] = 1'b0; tick(6);
      wr(3'd5, 32'hFFFF);

      // R10 enable gating
      wr(3'd2, 32'h0000_FFFE);
      gpi[0] = 1'b1; tick(12);
      rd_chk(3'd5, 32'h0001, "R10 disabled flag still latches");
      check("R10 disabled flag no smi", {31'h0, smi_o}, 32'h0);
      gpi[0] = 1'b0; tick(6);
      wr(3'd5, 32'hFFFF);
      wr(3'd2, 32'h0000_FFFF);

      // R2 inverted polarity
      wr(3'd0, 32'h0040); tick(12);
      rd_chk(3'd5, 32'h0040, "R2 active-low pin sets flag");
      wr(3'd0, 32'h0); tick(6);
      wr(3'd5, 32'hFFFF);

      // R4
      sleep_sel = 1'b1;
      gpi[7] = 1'b1; tick(6); gpi[7] = 1'b0; tick(40);
      rd_chk(3'd5, 32'h0, "R4 fast strobe ignored in sleep");
      gpi[7] = 1'b1; tick(40); gpi[7] = 1'b0; tick(40);
      rd_chk(3'd5, 32'h0080, "R4 slow strobe latches");
      wr(3'd5, 32'hFFFF);

      // R11
      wr(3'd3, 32'h0300);
      wr(3'd4, 32'h0100);
      gpi[8] = 1'b1; gpi[9] = 1'b1; tick(40);
      gpi[8] = 1'b0; gpi[9] = 1'b0; tick(40);
      rd_chk(3'd5, 32'h0300, "R11 wake sources latched");
      check("R11 wake from non-core", {31'h0, wake_o}, 32'h1);
      wr(3'd5, 32'h0200);
      rd_chk(3'd5, 32'h0100, "R11 core flag kept");
      check("R11 core masked in sleep", {31'h0, wake_o}, 32'h0);
      @(negedge clk); sleep_sel = 1'b0; #2;
      check("R11 core wakes when running", {31'h0, wake_o}, 32'h1);

      // R12
      rd_chk(3'd1, 32'h0000_0039, "R12 steering readback");
      rd_chk(3'd3, 32'h0300, "R12 wake enable readback");
      rd_chk(3'd4, 32'h0100, "R12 core mask readback");
      rd_chk(3'd6, 32'h0, "R12 word 6 reads zero");
      rd_chk(3'd7, 32'h0, "R12 word 7 reads zero");

      tick(4);
      done = 1'b1;
      finish_run();
   end

endmodule